// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block sits between a clocked host and an external asynchronous static RAM that has two byte lanes and a separate semaphore region. The host presents one write at a time: an address, a 16-bit word, two byte-enable bits, a bit that picks the memory array or the semaphore region, a bit that asks for output enable to stay low during the write, and a one-cycle request. The sequencer then drives the memory pins through a fixed order of phases and pulses `done_o` when the memory may be addressed again.

The phases are idle, address setup, strobe, data hold and recovery. Read/write goes low first. The chip or semaphore enable and the byte strobes go low only after the address setup count. All qualifiers return high together. The data bus stays driven for the hold count and is then released, and the recovery count runs before the next address change. Every count is a clock-cycle parameter. When output enable is kept low, the strobe phase is stretched so that the RAM's own outputs can turn off before the sequencer drives the bus and the data still meets its setup time. Every memory pin comes straight from a flip-flop, so none of them can glitch.

Top module: `sram_wseq`

## Requirements
- R1: After reset, and whenever no request is in progress, every active-low memory pin (`mem_ce_n_o`, `mem_sem_n_o`, `mem_ub_n_o`, `mem_lb_n_o`, `mem_rw_n_o`, `mem_oe_n_o`) is 1 and `mem_drive_o` and `done_o` are 0.
- R2: A request is taken only when the sequencer is idle. A request raised while a write is in progress changes neither the pins, the address, the data nor the phase lengths, and it starts no second write.
- R3: In the T_AS cycles that follow acceptance, `mem_rw_n_o` is 0 while every enable and byte strobe stays 1. No enable falls before read/write.
- R4: In an array write, during the strobe phase, `mem_ce_n_o`=0 and `mem_sem_n_o`=1. `mem_ub_n_o` is the inverse of byte-enable bit 1 and `mem_lb_n_o` is the inverse of byte-enable bit 0. `mem_rw_n_o`=0.
- R5: In a semaphore write, during the strobe phase, `mem_sem_n_o`=0 and `mem_rw_n_o`=0, while `mem_ce_n_o`, `mem_ub_n_o` and `mem_lb_n_o` stay 1.
- R6: The strobe phase lasts max(T_WP, T_DW) cycles when the output-enable-low bit is 0. It lasts max(T_WP, T_WZ+T_DW) cycles when that bit is 1. `mem_oe_n_o` equals the inverse of that bit for the whole request.
- R7: With output enable high, `mem_drive_o` is 1 from the first strobe cycle. With output enable low, it is 1 only from strobe cycle T_WZ (counted from 0). It stays 1 for the T_DH cycles after the strobes rise and is 0 at every other time.
- R8: After the hold phase, all pins stay inactive for T_WR cycles. `done_o` is 1 only in the last of those cycles, for exactly one cycle.
- R9: An array request with both byte enables 0 never lowers `mem_ce_n_o`, `mem_rw_n_o` or any strobe, never drives the bus, and raises `done_o` in the first cycle after acceptance.
- R10: `mem_addr_o` and `mem_wdata_o` hold the accepted values for the whole request. The address never changes while read/write, chip enable and a byte strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request, sampled in idle |
| req_sem_i | input | 1 | 1 selects the semaphore region, 0 the array |
| req_be_i | input | 2 | Byte enables: bit 1 upper lane, bit 0 lower lane |
| req_oe_low_i | input | 1 | Keep output enable low during this write |
| req_addr_i | input | AW | Write address |
| req_data_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | AW | Address to the RAM |
| mem_wdata_o | output | DW | Data to the RAM bus |
| mem_drive_o | output | 1 | Data bus drive enable |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_sem_n_o | output | 1 | Semaphore enable, active low |
| mem_ub_n_o | output | 1 | Upper byte strobe, active low |
| mem_lb_n_o | output | 1 | Lower byte strobe, active low |
| mem_rw_n_o | output | 1 | Read/write, low for write |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach from the ports is a request that arrives while a write is still in flight. It must neither restart the phase counter nor replace the latched address. The bench raises a second request with a different address and data during the setup phase. It then checks the pins cycle by cycle until the first write has ended, and for some idle cycles after it. The bench also sweeps every combination of target, byte enables and output-enable mode, including the empty array request. In each run it compares every pin against a timeline computed from the phase counts.

// File: rtl/sram_wseq_pkg.sv
package sram_wseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOVER
    } wseq_state_e;

endpackage

// File: rtl/sram_wseq_span.sv
module sram_wseq_span #(
    parameter int T_WP = 3,
    parameter int T_WZ = 2,
    parameter int T_DW = 2,
    parameter int CW   = 4
) (
    input  logic          oe_low,
    output logic [CW-1:0] strobe_len,
    output logic [CW-1:0] drive_from
);
    localparam int LEN_OE_HI = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int LEN_OE_LO = (T_WP > T_WZ + T_DW) ? T_WP : (T_WZ + T_DW);

    always_comb begin
        strobe_len = oe_low ? CW'(LEN_OE_LO) : CW'(LEN_OE_HI);
        drive_from = oe_low ? CW'(T_WZ) : '0;
    end
endmodule

// File: rtl/sram_wseq_lane_dec.sv
module sram_wseq_lane_dec (
    input  logic       is_sem,
    input  logic [1:0] be,
    output logic       ce_n,
    output logic       sem_n,
    output logic       ub_n,
    output logic       lb_n
);
    always_comb begin
        ce_n  = is_sem;
        sem_n = !is_sem;
        ub_n  = is_sem || !be[1];
        lb_n  = is_sem || !be[0];
    end
endmodule

// File: rtl/sram_wseq.sv
module sram_wseq
    import sram_wseq_pkg::*;
#(
    parameter int AW   = 13,
    parameter int DW   = 16,
    parameter int T_AS = 1,
    parameter int T_WP = 3,
    parameter int T_WZ = 2,
    parameter int T_DW = 2,
    parameter int T_DH = 1,
    parameter int T_WR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_sem_i,
    input  logic [1:0]    req_be_i,
    input  logic          req_oe_low_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    output logic          done_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_drive_o,
    output logic          mem_ce_n_o,
    output logic          mem_sem_n_o,
    output logic          mem_ub_n_o,
    output logic          mem_lb_n_o,
    output logic          mem_rw_n_o,
    output logic          mem_oe_n_o
);
    localparam int SUM_T = T_AS + T_WP + T_WZ + T_DW + T_DH + T_WR;
    localparam int CW    = $clog2(SUM_T + 1);

    typedef struct packed {
        wseq_state_e   state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [1:0]    be;
        logic          sem;
        logic          oel;
        logic          ce_n;
        logic          sem_n;
        logic          ub_n;
        logic          lb_n;
        logic          rw_n;
        logic          oe_n;
        logic          drv;
        logic          done;
    } wseq_reg_t;

    wseq_reg_t r_q, r_d;

    logic [CW-1:0] strobe_len, drive_from;
    logic          lane_ce_n, lane_sem_n, lane_ub_n, lane_lb_n;

    sram_wseq_span #(
        .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .CW(CW)
    ) u_span (
        .oe_low    (r_q.oel),
        .strobe_len(strobe_len),
        .drive_from(drive_from)
    );

    sram_wseq_lane_dec u_lane (
        .is_sem(r_q.sem),
        .be    (r_q.be),
        .ce_n  (lane_ce_n),
        .sem_n (lane_sem_n),
        .ub_n  (lane_ub_n),
        .lb_n  (lane_lb_n)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.addr = req_addr_i;
                    r_d.data = req_data_i;
                    r_d.be   = req_be_i;
                    r_d.sem  = req_sem_i;
                    r_d.oel  = req_oe_low_i;
                    if (!req_sem_i && req_be_i == 2'b00) begin
                        r_d.state = ST_RECOVER;
                        r_d.cnt   = CW'(1);
                    end else begin
                        r_d.state = ST_SETUP;
                        r_d.cnt   = CW'(T_AS);
                    end
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.state = ST_STROBE;
                    r_d.cnt   = strobe_len;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_STROBE: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.state = ST_HOLD;
                    r_d.cnt   = CW'(T_DH);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.state = ST_RECOVER;
                    r_d.cnt   = CW'(T_WR);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_RECOVER: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cnt   = '0;
            end
        endcase

        // Pin values for the coming cycle, derived from the next phase
        r_d.rw_n  = !(r_d.state == ST_SETUP || r_d.state == ST_STROBE);
        r_d.ce_n  = (r_d.state == ST_STROBE) ? lane_ce_n  : 1'b1;
        r_d.sem_n = (r_d.state == ST_STROBE) ? lane_sem_n : 1'b1;
        r_d.ub_n  = (r_d.state == ST_STROBE) ? lane_ub_n  : 1'b1;
        r_d.lb_n  = (r_d.state == ST_STROBE) ? lane_lb_n  : 1'b1;
        r_d.oe_n  = (r_d.state == ST_IDLE) || !r_d.oel;
        r_d.drv   = (r_d.state == ST_HOLD) ||
                    (r_d.state == ST_STROBE && r_d.cnt <= strobe_len - drive_from);
        r_d.done  = (r_d.state == ST_RECOVER) && (r_d.cnt == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.sem_n <= 1'b1;
            r_q.ub_n  <= 1'b1;
            r_q.lb_n  <= 1'b1;
            r_q.rw_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o      = r_q.done;
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.data;
    assign mem_drive_o = r_q.drv;
    assign mem_ce_n_o  = r_q.ce_n;
    assign mem_sem_n_o = r_q.sem_n;
    assign mem_ub_n_o  = r_q.ub_n;
    assign mem_lb_n_o  = r_q.lb_n;
    assign mem_rw_n_o  = r_q.rw_n;
    assign mem_oe_n_o  = r_q.oe_n;

    logic wr_qual;
    assign wr_qual = !mem_rw_n_o && !mem_ce_n_o && (!mem_ub_n_o || !mem_lb_n_o);

    // R3
    enable_after_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rw_n_o) |-> (mem_ce_n_o && mem_sem_n_o));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_qual && $past(wr_qual)) |-> $stable(mem_addr_o));

    // R4
    ce_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n_o |-> (!mem_rw_n_o && mem_sem_n_o));

    // R5
    sem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sem_n_o |-> (mem_ce_n_o && mem_ub_n_o && mem_lb_n_o && !mem_rw_n_o));

    // R7
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive_o |-> (!mem_rw_n_o || (mem_ce_n_o && mem_sem_n_o && mem_ub_n_o && mem_lb_n_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_rw_n_o && mem_ce_n_o && mem_sem_n_o && !mem_drive_o));
endmodule

// File: tb/sram_wseq_bench.sv
module sram_wseq_bench;
    localparam int AW   = 13;
    localparam int DW   = 16;
    localparam int T_AS = 2;
    localparam int T_WP = 3;
    localparam int T_WZ = 2;
    localparam int T_DW = 2;
    localparam int T_DH = 2;
    localparam int T_WR = 2;
    localparam real CLK_NS = 8.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          req_sem_i = 1'b0;
    logic [1:0]    req_be_i = '0;
    logic          req_oe_low_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_data_i = '0;
    logic          done_o, mem_drive_o, mem_ce_n_o, mem_sem_n_o;
    logic          mem_ub_n_o, mem_lb_n_o, mem_rw_n_o, mem_oe_n_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_NS / 2.0) clk = !clk;

    sram_wseq #(
        .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
        .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
    ) u_sram_wseq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_sem_i(req_sem_i),
        .req_be_i(req_be_i), .req_oe_low_i(req_oe_low_i),
        .req_addr_i(req_addr_i), .req_data_i(req_data_i),
        .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_drive_o(mem_drive_o), .mem_ce_n_o(mem_ce_n_o),
        .mem_sem_n_o(mem_sem_n_o), .mem_ub_n_o(mem_ub_n_o),
        .mem_lb_n_o(mem_lb_n_o), .mem_rw_n_o(mem_rw_n_o),
        .mem_oe_n_o(mem_oe_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] pins();
        return {mem_rw_n_o, mem_ce_n_o, mem_sem_n_o, mem_ub_n_o, mem_lb_n_o};
    endfunction

    task automatic check_idle(input string tag);
        check({tag, " R1 pins"}, {27'd0, pins()}, 32'h1f);
        check({tag, " R1 oe"}, {31'd0, mem_oe_n_o}, 32'd1);
        check({tag, " R1 drive"}, {31'd0, mem_drive_o}, 32'd0);
        check({tag, " R1 done"}, {31'd0, done_o}, 32'd0);
    endtask

    task automatic run_req(input logic sem, input logic oel, input logic [1:0] be,
                           input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit poke);
        int plen, total;
        bit empty;
        plen  = oel ? ((T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW)
                    : ((T_WP > T_DW) ? T_WP : T_DW);
        empty = !sem && (be == 2'b00);
        total = empty ? 1 : (T_AS + plen + T_DH + T_WR);
        @(negedge clk);
        req_i = 1'b1; req_sem_i = sem; req_oe_low_i = oel; req_be_i = be;
        req_addr_i = a; req_data_i = d;
        for (int k = 0; k <= total + 2; k++) begin
            logic [4:0] e_pins;
            logic e_drv, e_done, e_oe;
            string ph;
            @(negedge clk);
            req_i = 1'b0;
            if (poke && k == 0) begin
                req_i = 1'b1; req_sem_i = !sem; req_be_i = ~be;
                req_oe_low_i = !oel; req_addr_i = ~a; req_data_i = ~d;
            end
            e_pins = 5'h1f; e_drv = 1'b0; e_done = 1'b0; e_oe = 1'b1; ph = "R1";
            if (k < total) begin
                e_oe = !oel;
                if (empty) begin
                    e_done = 1'b1; ph = "R9";
                end else if (k < T_AS) begin
                    e_pins = 5'b0_1111; ph = "R3";
                end else if (k < T_AS + plen) begin
                    e_pins = sem ? 5'b0_1011 : {3'b001, !be[1], !be[0]};
                    e_drv  = !oel || (k - T_AS >= T_WZ);
                    ph = sem ? "R5" : "R4";
                end else if (k < T_AS + plen + T_DH) begin
                    e_drv = 1'b1; ph = "R7";
                end else begin
                    e_done = (k == total - 1); ph = "R8";
                end
            end
            if (poke) ph = {ph, " R2"};
            check({ph, " R6 strobes"}, {27'd0, pins()}, {27'd0, e_pins});
            check({ph, " R7 drive"}, {31'd0, mem_drive_o}, {31'd0, e_drv});
            check({ph, " R8 done"}, {31'd0, done_o}, {31'd0, e_done});
            check({ph, " R6 oe"}, {31'd0, mem_oe_n_o}, {31'd0, e_oe});
            if (k < total) begin
                check({ph, " R10 addr"}, {{(32-AW){1'b0}}, mem_addr_o}, {{(32-AW){1'b0}}, a});
                check({ph, " R10 data"}, {{(32-DW){1'b0}}, mem_wdata_o}, {{(32-DW){1'b0}}, d});
            end
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 2; o++)
                for (int b = 0; b < 4; b++)
                    run_req(s[0], o[0], b[1:0], AW'(13'h0a5 + 37 * (s * 8 + o * 4 + b)),
                            DW'(16'h1234 * (b + 1) + 16'h0f0 * s + o), 1'b0);
        run_req(1'b0, 1'b1, 2'b10, 13'h1abc, 16'hbeef, 1'b1);
        run_req(1'b1, 1'b0, 2'b00, 13'h0042, 16'h5a5a, 1'b1);
        run_req(1'b0, 1'b0, 2'b00, 13'h0777, 16'hc3c3, 1'b0);
        @(negedge clk);
        check_idle("final");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule